// File: doc/BRIEF.md
# Separable-Code Two-Rail Error Checker

This block watches words of a separable code and reports whether each one is a valid codeword. Every word holds K data bits and R check bits. The block recomputes the check bits from the data it receives and inverts each recomputed bit. It then pairs each inverted bit with the matching received check bit. When the word is valid, each of these pairs is complementary. A tree of two-rail combining cells reduces the R pairs to one output pair.

The output is never a single flag. A pair of 01 or 10 means the word is a codeword, and 00 or 11 means an error. Because of this, a line stuck in the checker itself also appears as an error indication. Across the set of valid words, both good values occur.

The datapath is purely combinational. An optional output stage, selected by a parameter, delays the pair by one clock so it can be placed at a register boundary. The block only checks words. It neither generates nor corrects them.

Top module: `tscSepChecker`

## Requirements
- R1: The word is split with data bits at codeWord[K+R-1:R] and check bits at codeWord[R-1:0].
- R2: Check bit i is the XOR (even parity) of every data bit j, counted from 0 at codeWord[R], with j mod R equal to i. Flipping two data bits that share a residue therefore leaves the word valid.
- R3: A valid codeword gives an output pair {errRail0, errRail1} of 01 or 10.
- R4: Flipping any single data bit of a valid codeword gives a pair of 00 or 11.
- R5: Flipping any single check bit of a valid codeword gives a pair of 00 or 11.
- R6: The pair is good (01 or 10) only when every check position agrees. Any number of disagreeing positions gives 00 or 11.
- R7: Both good values occur over the set of valid codewords. The all-zero word and the word with only data bit 0 and check bit 0 set give opposite good values.
- R8: With REGISTERED=1, the pair shows the result for the word that was present at the previous rising clock edge. While rstN is low, the pair reads 00.
- R9: With REGISTERED=0, the pair follows the present word with no clock edge involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rstN | input | 1 | Active-low reset of the output stage |
| codeWord | input | K+R | Received word: data above, check bits below |
| errRail0 | output | 1 | First rail of the result pair |
| errRail1 | output | 1 | Second rail of the result pair |

## Verification
The bench builds two copies with K=8 and R=3: one combinational (REGISTERED=0) and one registered (REGISTERED=1). With R=3 the rail tree is unbalanced: one leaf sits directly under the root and two sit one level lower. The bench uses this to show that every leaf depth can pull the result bad, and that a single leaf value can swap the good output between 01 and 10. With eight data bits spread over three residues, positions 0 and 1 get three data bits each and position 2 gets two. This makes it possible to test pairs of data flips that cancel and pairs that do not.

// File: rtl/tscPkg.sv
package tscPkg;

  typedef struct packed {
    logic r0;
    logic r1;
  } railPair_t;

  // Combine two pairs: output is complementary only if both inputs are.
  function automatic railPair_t railCell(input railPair_t a, input railPair_t b);
    railPair_t z;
    z.r0 = (a.r0 & b.r0) | (a.r1 & b.r1);
    z.r1 = (a.r0 & b.r1) | (a.r1 & b.r0);
    return z;
  endfunction

  function automatic logic pairGood(input railPair_t p);
    return p.r0 ^ p.r1;
  endfunction

endpackage

// File: rtl/tscCheckGen.sv
module tscCheckGen #(
  parameter int K = 8,
  parameter int R = 3
) (
  input  logic [K-1:0] dataBits,
  output logic [R-1:0] invPred
);

  logic [R-1:0] predBits;

  // Residue-interleaved even parity over the data field.
  always_comb begin
    predBits = '0;
    for (int j = 0; j < K; j++) begin
      predBits[j % R] = predBits[j % R] ^ dataBits[j];
    end
  end

  assign invPred = ~predBits;

endmodule

// File: rtl/tscRailTree.sv
module tscRailTree
  import tscPkg::*;
#(
  parameter int R = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic [R-1:0] leafR0,
  input  logic [R-1:0] leafR1,
  output railPair_t rootPair
);

  localparam int NODES = 2 * R - 1;
  localparam int FIRST_LEAF = R - 1;

  railPair_t node [NODES];
  logic [R-1:0] leafGood;

  genvar g;
  generate
    for (g = 0; g < R; g++) begin : gLeaf
      assign node[FIRST_LEAF + g] = '{r0: leafR0[g], r1: leafR1[g]};
      assign leafGood[g] = leafR0[g] ^ leafR1[g];
    end
    for (g = 0; g < FIRST_LEAF; g++) begin : gCell
      assign node[g] = railCell(node[2 * g + 1], node[2 * g + 2]);
    end
  endgenerate

  assign rootPair = node[0];

  AST_ROOT_GOOD_ALL_LEAVES: assert property (@(posedge clk) disable iff (!rstN)
    pairGood(rootPair) |-> ($countones(leafGood) == R)); // R6
  AST_ALL_LEAVES_ROOT_GOOD: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(leafGood) == R) |-> pairGood(rootPair)); // R3

endmodule

// File: rtl/tscOutStage.sv
module tscOutStage
  import tscPkg::*;
#(
  parameter bit REGISTERED = 1'b0
) (
  input  logic      clk,
  input  logic      rstN,
  input  railPair_t inPair,
  output railPair_t outPair
);

  generate
    if (REGISTERED) begin : gReg
      railPair_t heldPair;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) heldPair <= '0;
        else       heldPair <= inPair;
      end
      assign outPair = heldPair;

      AST_REG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
        $past(rstN) |-> (outPair == $past(inPair))); // R8
      AST_RESET_READS_BAD: assert property (@(posedge clk) disable iff (!rstN)
        $rose(rstN) |-> (outPair == '0)); // R8
    end else begin : gComb
      assign outPair = inPair;
    end
  endgenerate

endmodule

// File: rtl/tscSepChecker.sv
module tscSepChecker
  import tscPkg::*;
#(
  parameter int K = 8,
  parameter int R = 3,
  parameter bit REGISTERED = 1'b0
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [K+R-1:0] codeWord,
  output logic           errRail0,
  output logic           errRail1
);

  localparam int N = K + R;

  logic [K-1:0] dataBits;
  logic [R-1:0] chkBits;
  logic [R-1:0] invPred;
  railPair_t rootPair;
  railPair_t finalPair;

  assign dataBits = codeWord[N-1:R]; // R1
  assign chkBits  = codeWord[R-1:0];

  tscCheckGen #(.K(K), .R(R)) uGen (
    .dataBits(dataBits),
    .invPred (invPred)
  );

  tscRailTree #(.R(R)) uTree (
    .clk     (clk),
    .rstN    (rstN),
    .leafR0  (chkBits),
    .leafR1  (invPred),
    .rootPair(rootPair)
  );

  tscOutStage #(.REGISTERED(REGISTERED)) uOut (
    .clk    (clk),
    .rstN   (rstN),
    .inPair (rootPair),
    .outPair(finalPair)
  );

  assign errRail0 = finalPair.r0;
  assign errRail1 = finalPair.r1;

  AST_CODEWORD_GOOD: assert property (@(posedge clk) disable iff (!rstN)
    ((chkBits ^ invPred) == {R{1'b1}}) |-> (rootPair.r0 != rootPair.r1)); // R3
  AST_MISMATCH_BAD: assert property (@(posedge clk) disable iff (!rstN)
    ((chkBits ^ invPred) != {R{1'b1}}) |-> (rootPair.r0 == rootPair.r1)); // R6

endmodule

// File: tb/tscSepChecker_test.sv
module tscSepChecker_test;

  localparam int K = 8;
  localparam int R = 3;
  localparam int N = K + R;

  localparam logic [K-1:0] dataTab [12] = '{
    8'h00, 8'h01, 8'h02, 8'h04, 8'h80, 8'hFF,
    8'hA5, 8'h5A, 8'h3C, 8'h96, 8'h7E, 8'h11
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] wordIn = '0;
  logic combR0, combR1, regR0, regR1;

  int checks = 0;
  int fails = 0;
  bit seen01 = 1'b0;
  bit seen10 = 1'b0;

  always #4 clk = ~clk;

  tscSepChecker #(.K(K), .R(R), .REGISTERED(1'b1)) uut (
    .clk(clk), .rstN(rstN), .codeWord(wordIn), .errRail0(regR0), .errRail1(regR1)
  );

  tscSepChecker #(.K(K), .R(R), .REGISTERED(1'b0)) uutComb (
    .clk(clk), .rstN(rstN), .codeWord(wordIn), .errRail0(combR0), .errRail1(combR1)
  );

  function automatic logic [N-1:0] codeOf(input logic [K-1:0] d);
    logic [R-1:0] c;
    c = '0;
    for (int j = 0; j < K; j++) c[j % R] ^= d[j];
    return {d, c};
  endfunction

  task automatic check(input bit ok, input string req, input logic [1:0] act, input string expd);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %b expected %s", req, act, expd);
    end
  endtask

  task automatic drive(input logic [N-1:0] w);
    @(negedge clk);
    wordIn = w;
    #1;
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [1:0] zeroVal, oneVal, held;
    // Reset state of registered copy (R8)
    wordIn = codeOf(8'h00);
    @(posedge clk); #1;
    check({regR0, regR1} == 2'b00, "R8 reset", {regR0, regR1}, "00");
    @(negedge clk) rstN = 1'b1;

    // Vector table: codeword, register latency, all single flips
    for (int t = 0; t < 12; t++) begin
      logic [N-1:0] cw;
      cw = codeOf(dataTab[t]);
      drive(cw);
      check(combR0 != combR1, "R3 codeword", {combR0, combR1}, "01 or 10");
      if ({combR0, combR1} == 2'b01) seen01 = 1'b1;
      if ({combR0, combR1} == 2'b10) seen10 = 1'b1;
      held = {combR0, combR1};
      @(posedge clk); #1;
      check({regR0, regR1} == held, "R8 latency", {regR0, regR1}, "comb value of previous word");
      for (int b = 0; b < N; b++) begin
        drive(cw ^ (N'(1) << b));
        if (b >= R)
          check(combR0 == combR1, "R4 data flip", {combR0, combR1}, "00 or 11");
        else
          check(combR0 == combR1, "R5 check flip", {combR0, combR1}, "00 or 11");
      end
    end

    // R7: both good values seen, and a single leaf value swaps the result
    check(seen01 && seen10, "R7 both values", {seen01, seen10}, "11");
    drive(N'(0));
    zeroVal = {combR0, combR1};
    drive({8'h01, 3'b001});
    oneVal = {combR0, combR1};
    check((oneVal ^ zeroVal) == 2'b11 && oneVal[0] != oneVal[1], "R7 swap", oneVal, "inverse of zero-word pair");

    // R9: combinational copy responds mid-cycle without a clock edge
    @(posedge clk); #2;
    wordIn = N'(0);
    #1;
    check(combR0 != combR1, "R9 no clock", {combR0, combR1}, "good");
    wordIn = N'(1);
    #1;
    check(combR0 == combR1, "R9 no clock", {combR0, combR1}, "bad");

    // R6: multiple mismatches
    drive(codeOf(8'h00) ^ N'(3));
    check(combR0 == combR1, "R6 two check flips", {combR0, combR1}, "00 or 11");
    drive(codeOf(8'h00) ^ (N'(3) << R));
    check(combR0 == combR1, "R6 two data flips", {combR0, combR1}, "00 or 11");
    drive(codeOf(8'h00) ^ N'(7));
    check(combR0 == combR1, "R6 all check flips", {combR0, combR1}, "00 or 11");

    // R2 and R1: data bits 0 and 3 share residue 0, so flipping both is valid
    drive(codeOf(8'h5A) ^ (N'(9) << R));
    check(combR0 != combR1, "R2 cancelling flips", {combR0, combR1}, "01 or 10");
    drive({8'h04, 3'b100});
    check(combR0 != combR1, "R1 layout data bit 2 to check bit 2", {combR0, combR1}, "01 or 10");

    // R8: reset in mid-run forces 00
    @(negedge clk) rstN = 1'b0;
    #1;
    check({regR0, regR1} == 2'b00, "R8 mid reset", {regR0, regR1}, "00");
    @(negedge clk) rstN = 1'b1;
    @(posedge clk); #1;
    check(regR0 != regR1, "R8 after reset", {regR0, regR1}, "good pair");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule